// File: doc/BRIEF.md
# Serial Flash Page-Program Command Engine

This block is the device-side command logic of a serial NOR flash for the page-program path. It watches a mode-0 serial port (active-low select, clock idling low, data sampled on the rising clock edge, most significant bit first) through synchronisers running on the system clock. It recognises a write-enable opcode (06h) and a page-program opcode (02h) followed by a 24-bit address and one or more data bytes. Incoming data bytes are collected in a page-sized staging buffer, placed from the low address byte onward and wrapping inside the page, with a per-offset flag recording which offsets were received.

When select rises cleanly on a byte boundary after at least one data byte, and the write-enable flag was set and the addressed page is not locked, the engine starts a self-timed program cycle lasting `T_PP` clock cycles. During that cycle it walks the flagged offsets in ascending order, reads each old array byte, and writes back the old value ANDed with the new one, so bits only go from 1 to 0. A write-in-progress output is high for the whole cycle, and the write-enable flag clears on the cycle it ends. The storage array is outside the block and is reached through a simple read/write port with one cycle of read latency.

The command decoder has states DEC_IDLE, DEC_OPCODE, DEC_ADDR, DEC_DATA and DEC_SKIP. Any state goes to DEC_IDLE when select is high; DEC_IDLE goes to DEC_OPCODE when select is low; DEC_OPCODE goes to DEC_ADDR on an accepted page-program opcode and to DEC_SKIP on any other byte; DEC_ADDR goes to DEC_DATA after the third address byte; DEC_DATA and DEC_SKIP stay until select rises. The program sequencer has states SEQ_IDLE, SEQ_SCAN, SEQ_READ, SEQ_WRITE and SEQ_HOLD: SEQ_IDLE goes to SEQ_SCAN on a start; SEQ_SCAN goes to SEQ_READ on a flagged offset, advances past unflagged ones, and goes to SEQ_HOLD after the last offset; SEQ_READ always goes to SEQ_WRITE; SEQ_WRITE returns to SEQ_SCAN, or to SEQ_HOLD after the last offset; SEQ_HOLD returns to SEQ_IDLE when the cycle timer expires.

Top module: `spi_pp_engine`

## Requirements
- R1: A write-enable frame (opcode 06h, exactly 8 bits, then select high) sets the `wel` output; `wel` is 0 after reset.
- R2: A page-program frame (opcode 02h, then three address bytes MSB first, then data bytes) is accepted only if `wel` is 1 when the opcode completes; otherwise no program cycle starts and no array access occurs.
- R3: The first data byte goes to the page offset given by address bits 7:0, each later byte to the next offset, and offset 255 is followed by offset 0 of the same page.
- R4: When more than 256 data bytes arrive, each offset keeps the last byte received for it.
- R5: Only offsets that received a data byte are written to the array; other bytes of the page see no write.
- R6: If select rises when a partial byte has been shifted, or before any data byte, the command is dropped: no program cycle starts and `wel` keeps its value.
- R7: An accepted command raises `wip` and keeps it high for exactly `T_PP` clock cycles; `wip` is 0 after reset.
- R8: `wel` returns to 0 on the same clock edge at which `wip` falls at the end of a program cycle, and at no other time.
- R9: If `page_locked` is high when select rises at the end of a program frame, the command is not executed.
- R10: Address bits 23 and 22 are ignored; `arr_addr` is address bits 21:0 (page in bits 21:8, offset in bits 7:0).
- R11: Each array write carries the old array byte ANDed with the new data; the old byte is read with `arr_rd` exactly one cycle before the matching `arr_we`.
- R12: While `wip` is 1, page-program and write-enable frames are ignored and `cmd_page` holds its value.
- R13: `arr_rd` and `arr_we` are asserted only while `wip` is 1 and never together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock, idle low, data sampled on rising edge |
| spi_mosi | input | 1 | Serial data into the device |
| page_locked | input | 1 | High when the page shown on `cmd_page` is protected |
| cmd_page | output | 14 | Page index of the last decoded address (bits 21:8) |
| arr_rdata | input | 8 | Array read data, valid the cycle after `arr_rd` |
| arr_rd | output | 1 | Array read strobe |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 22 | Array byte address |
| arr_wdata | output | 8 | Array write data (old AND new) |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable flag |

## Verification
The bound checker watches, on every cycle, the orderings that hold regardless of traffic: array strobes only inside a program cycle and never together, each write preceded by its read, a program cycle starting only with the write-enable flag set and the page unlocked, the flag clearing only together with the end of the cycle, and the page index frozen while the cycle runs. Data placement (offset, wrap, last-256 retention), the AND merge, the exact length of the program cycle and the dropping of badly terminated or ignored frames depend on the byte stream and are shown only by the bench scenarios, which compare every array write against an independently built expected list and then read back the model array.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;

    localparam logic [7:0] OP_PROGRAM = 8'h02;
    localparam logic [7:0] OP_WREN    = 8'h06;

    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_OPCODE,
        DEC_ADDR,
        DEC_DATA,
        DEC_SKIP
    } dec_state_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SCAN,
        SEQ_READ,
        SEQ_WRITE,
        SEQ_HOLD
    } seq_state_t;

endpackage

// File: rtl/spi_pp_frontend.sv
// Synchronises the serial pins and produces bit strobes and select edges.
module spi_pp_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn_in,
    input  logic sck_in,
    input  logic mosi_in,
    output logic sel,
    output logic bit_stb,
    output logic bit_val,
    output logic cs_rise
);

    logic [SYNC_STAGES-1:0] csn_sync;
    logic [SYNC_STAGES-1:0] sck_sync;
    logic [SYNC_STAGES-1:0] mosi_sync;
    logic                   csn_prev;
    logic                   sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_sync  <= '1;
            sck_sync  <= '0;
            mosi_sync <= '0;
            csn_prev  <= 1'b1;
            sck_prev  <= 1'b0;
        end else begin
            csn_sync  <= {csn_sync[SYNC_STAGES-2:0], csn_in};
            sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_in};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_in};
            csn_prev  <= csn_sync[SYNC_STAGES-1];
            sck_prev  <= sck_sync[SYNC_STAGES-1];
        end
    end

    always_comb begin
        sel     = ~csn_sync[SYNC_STAGES-1];
        cs_rise = csn_sync[SYNC_STAGES-1] & ~csn_prev;
        bit_stb = sck_sync[SYNC_STAGES-1] & ~sck_prev & ~csn_sync[SYNC_STAGES-1];
        bit_val = mosi_sync[SYNC_STAGES-1];
    end

endmodule

// File: rtl/spi_pp_decoder.sv
// Command decoder: opcode, address, data placement and write-enable flag.
module spi_pp_decoder
    import spi_pp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DC_BITS   = 2,
    parameter int PAGE_BITS = 8,
    parameter int AW_K      = ADDR_W - DC_BITS,
    parameter int PG_W      = AW_K - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 cs_rise,
    input  logic                 busy,
    input  logic                 prog_done,
    input  logic                 page_locked,
    output logic                 wel,
    output logic                 start,
    output logic [PG_W-1:0]      page,
    output logic                 buf_clear,
    output logic                 buf_we,
    output logic [PAGE_BITS-1:0] buf_off,
    output logic [7:0]           buf_wdata
);

    localparam int ADDR_BYTES = ADDR_W / 8;

    dec_state_t state_q, state_d;

    logic [2:0]           bit_cnt_q;
    logic [6:0]           shift_q;
    logic [1:0]           abyte_q;
    logic [AW_K-1:0]      addr_q;
    logic [PAGE_BITS-1:0] off_q;
    logic                 got_data_q;
    logic                 wren_q;
    logic                 wel_q;

    logic                 byte_done;
    logic [7:0]           byte_val;
    logic [AW_K-1:0]      addr_next;
    logic                 accept;
    logic                 last_addr;
    logic                 data_byte;

    always_comb begin
        byte_done = bit_stb && (bit_cnt_q == 3'd7);
        byte_val  = {shift_q, bit_val};
        addr_next = {addr_q[AW_K-9:0], byte_val};
        accept    = (state_q == DEC_OPCODE) && byte_done &&
                    (byte_val == OP_PROGRAM) && wel_q && !busy;
        last_addr = (state_q == DEC_ADDR) && byte_done &&
                    (abyte_q == 2'(ADDR_BYTES - 1));
        data_byte = (state_q == DEC_DATA) && byte_done;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = DEC_IDLE;
        end else begin
            unique case (state_q)
                DEC_IDLE:   state_d = DEC_OPCODE;
                DEC_OPCODE: if (byte_done) state_d = accept ? DEC_ADDR : DEC_SKIP;
                DEC_ADDR:   if (last_addr) state_d = DEC_DATA;
                DEC_DATA:   state_d = DEC_DATA;
                DEC_SKIP:   state_d = DEC_SKIP;
                default:    state_d = DEC_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            abyte_q    <= '0;
            addr_q     <= '0;
            off_q      <= '0;
            got_data_q <= 1'b0;
            wren_q     <= 1'b0;
            wel_q      <= 1'b0;
        end else begin
            if (!sel)         bit_cnt_q <= '0;
            else if (bit_stb) bit_cnt_q <= bit_cnt_q + 3'd1;

            if (bit_stb) shift_q <= {shift_q[5:0], bit_val};

            if (accept)                                abyte_q <= '0;
            else if (state_q == DEC_ADDR && byte_done) abyte_q <= abyte_q + 2'd1;

            if (state_q == DEC_ADDR && byte_done) addr_q <= addr_next;

            if (last_addr)      off_q <= addr_next[PAGE_BITS-1:0];
            else if (data_byte) off_q <= off_q + 1'b1;

            if (accept)         got_data_q <= 1'b0;
            else if (data_byte) got_data_q <= 1'b1;

            if (state_q == DEC_OPCODE && byte_done) wren_q <= (byte_val == OP_WREN);
            else if (bit_stb || !sel)               wren_q <= 1'b0;

            if (prog_done)                      wel_q <= 1'b0;
            else if (cs_rise && wren_q && !busy) wel_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        wel       = wel_q;
        page      = addr_q[AW_K-1:PAGE_BITS];
        buf_clear = accept;
        buf_we    = data_byte;
        buf_off   = off_q;
        buf_wdata = byte_val;
        start     = cs_rise && (state_q == DEC_DATA) && (bit_cnt_q == 3'd0) &&
                    got_data_q && !page_locked && !busy;
    end

endmodule

// File: rtl/spi_pp_pagebuf.sv
// Page staging buffer with a received-offset flag per byte.
module spi_pp_pagebuf #(
    parameter int PAGE_BITS = 8,
    parameter int PAGE_SZ   = 1 << PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 we,
    input  logic [PAGE_BITS-1:0] waddr,
    input  logic [7:0]           wdata,
    input  logic [PAGE_BITS-1:0] raddr,
    output logic [7:0]           rdata,
    output logic                 rflag
);

    logic [7:0]         mem_q [PAGE_SZ];
    logic [PAGE_SZ-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q        <= '0;
        else if (clear) flag_q        <= '0;
        else if (we)    flag_q[waddr] <= 1'b1;
    end

    always_comb begin
        rdata = mem_q[raddr];
        rflag = flag_q[raddr];
    end

endmodule

// File: rtl/spi_pp_sequencer.sv
// Self-timed program cycle: walks flagged offsets, read-AND-write, then holds.
module spi_pp_sequencer
    import spi_pp_pkg::*;
#(
    parameter int PAGE_BITS = 8,
    parameter int PG_W      = 14,
    parameter int T_PP      = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [PG_W-1:0]           page,
    output logic [PAGE_BITS-1:0]      buf_off,
    input  logic [7:0]                buf_rdata,
    input  logic                      buf_flag,
    input  logic [7:0]                arr_rdata,
    output logic                      busy,
    output logic                      done,
    output logic                      arr_rd,
    output logic                      arr_we,
    output logic [PG_W+PAGE_BITS-1:0] arr_addr,
    output logic [7:0]                arr_wdata
);

    localparam int TIMER_W = $clog2(T_PP + 1);
    localparam logic [TIMER_W-1:0] TIMER_END = TIMER_W'(T_PP - 1);
    localparam logic [PAGE_BITS-1:0] LAST_OFF = '1;

    seq_state_t state_q, state_d;

    logic [PAGE_BITS-1:0] off_q;
    logic [TIMER_W-1:0]   timer_q;
    logic                 at_last;
    logic                 expired;

    always_comb begin
        at_last = (off_q == LAST_OFF);
        expired = (timer_q >= TIMER_END);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_SCAN;
            SEQ_SCAN:  begin
                if (buf_flag)     state_d = SEQ_READ;
                else if (at_last) state_d = SEQ_HOLD;
            end
            SEQ_READ:  state_d = SEQ_WRITE;
            SEQ_WRITE: state_d = at_last ? SEQ_HOLD : SEQ_SCAN;
            SEQ_HOLD:  if (expired) state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // offset walker and cycle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            timer_q <= '0;
        end else begin
            if (state_q == SEQ_IDLE) begin
                off_q   <= '0;
                timer_q <= '0;
            end else begin
                timer_q <= timer_q + 1'b1;
                if ((state_q == SEQ_SCAN && !buf_flag && !at_last) ||
                    (state_q == SEQ_WRITE && !at_last))
                    off_q <= off_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != SEQ_IDLE);
        done      = (state_q == SEQ_HOLD) && expired;
        arr_rd    = (state_q == SEQ_READ);
        arr_we    = (state_q == SEQ_WRITE);
        arr_addr  = {page, off_q};
        arr_wdata = arr_rdata & buf_rdata;
        buf_off   = off_q;
    end

endmodule

// File: rtl/spi_pp_engine.sv
// Top: serial page-program command engine.
module spi_pp_engine #(
    parameter int ADDR_W      = 24,
    parameter int DC_BITS     = 2,
    parameter int PAGE_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int T_PP        = 1000,
    parameter int AW_K        = ADDR_W - DC_BITS,
    parameter int PG_W        = AW_K - PAGE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_csn,
    input  logic            spi_sck,
    input  logic            spi_mosi,
    input  logic            page_locked,
    output logic [PG_W-1:0] cmd_page,
    input  logic [7:0]      arr_rdata,
    output logic            arr_rd,
    output logic            arr_we,
    output logic [AW_K-1:0] arr_addr,
    output logic [7:0]      arr_wdata,
    output logic            wip,
    output logic            wel
);

    logic                 sel, bit_stb, bit_val, cs_rise;
    logic                 start, prog_done, busy;
    logic                 buf_clear, buf_we, buf_flag;
    logic [PAGE_BITS-1:0] buf_woff, buf_roff;
    logic [7:0]           buf_wdata, buf_rdata;

    spi_pp_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .csn_in  (spi_csn),
        .sck_in  (spi_sck),
        .mosi_in (spi_mosi),
        .sel     (sel),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .cs_rise (cs_rise)
    );

    spi_pp_decoder #(
        .ADDR_W    (ADDR_W),
        .DC_BITS   (DC_BITS),
        .PAGE_BITS (PAGE_BITS),
        .AW_K      (AW_K),
        .PG_W      (PG_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .cs_rise     (cs_rise),
        .busy        (busy),
        .prog_done   (prog_done),
        .page_locked (page_locked),
        .wel         (wel),
        .start       (start),
        .page        (cmd_page),
        .buf_clear   (buf_clear),
        .buf_we      (buf_we),
        .buf_off     (buf_woff),
        .buf_wdata   (buf_wdata)
    );

    spi_pp_pagebuf #(.PAGE_BITS(PAGE_BITS)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (buf_clear),
        .we    (buf_we),
        .waddr (buf_woff),
        .wdata (buf_wdata),
        .raddr (buf_roff),
        .rdata (buf_rdata),
        .rflag (buf_flag)
    );

    spi_pp_sequencer #(
        .PAGE_BITS (PAGE_BITS),
        .PG_W      (PG_W),
        .T_PP      (T_PP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .page      (cmd_page),
        .buf_off   (buf_roff),
        .buf_rdata (buf_rdata),
        .buf_flag  (buf_flag),
        .arr_rdata (arr_rdata),
        .busy      (busy),
        .done      (prog_done),
        .arr_rd    (arr_rd),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

    assign wip = busy;

endmodule

// File: rtl/spi_pp_engine_chk.sv
// Port-level protocol checks, bound to the top module.
module spi_pp_engine_chk #(
    parameter int PG_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            page_locked,
    input logic [PG_W-1:0] cmd_page,
    input logic            arr_rd,
    input logic            arr_we,
    input logic            wip,
    input logic            wel
);

    // R13
    rd_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |-> wip);

    // R13
    we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wip);

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd, arr_we}));

    // R11
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(arr_rd));

    // R2
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> wel);

    // R9
    start_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> !$past(page_locked));

    // R8
    wel_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> $fell(wip));

    // R12
    page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> $stable(cmd_page));

endmodule

bind spi_pp_engine spi_pp_engine_chk #(.PG_W(PG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_locked (page_locked),
    .cmd_page    (cmd_page),
    .arr_rd      (arr_rd),
    .arr_we      (arr_we),
    .wip         (wip),
    .wel         (wel)
);

// File: tb/spi_pp_engine_test.sv
module spi_pp_engine_test;

    localparam int T_PP   = 800;
    localparam int HALF   = 3;
    localparam int AW_K   = 22;
    localparam int PG_W   = 14;

    typedef struct packed {
        logic [AW_K-1:0] a;
        logic [7:0]      d;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            spi_csn = 1'b1;
    logic            spi_sck = 1'b0;
    logic            spi_mosi = 1'b0;
    logic            page_locked;
    logic [PG_W-1:0] cmd_page;
    logic [7:0]      arr_rdata = 8'h00;
    logic            arr_rd, arr_we;
    logic [AW_K-1:0] arr_addr;
    logic [7:0]      arr_wdata;
    logic            wip, wel;

    logic [PG_W-1:0] lock_pg = '0;
    logic            lock_en = 1'b0;
    assign page_locked = lock_en && (cmd_page == lock_pg);

    int tests = 0;
    int fails = 0;
    int wip_cycles = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:1023];
    logic [7:0] payload [0:299];
    exp_t sb_q[$];

    always #4 clk = ~clk;

    spi_pp_engine #(.T_PP(T_PP)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_csn     (spi_csn),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .page_locked (page_locked),
        .cmd_page    (cmd_page),
        .arr_rdata   (arr_rdata),
        .arr_rd      (arr_rd),
        .arr_we      (arr_we),
        .arr_addr    (arr_addr),
        .arr_wdata   (arr_wdata),
        .wip         (wip),
        .wel         (wel)
    );

    // array model: registered read, write on strobe
    always @(posedge clk) begin
        if (arr_rd) arr_rdata <= mem[arr_addr[9:0]];
        if (arr_we) mem[arr_addr[9:0]] <= arr_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every array write
    always @(negedge clk) begin
        if (wip) wip_cycles++;
        if (rst_n && arr_we) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5", "unexpected array write addr", int'(arr_addr), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(arr_addr == e.a, "R3", "write address", int'(arr_addr), int'(e.a));
                check(arr_wdata == e.d, "R11", "write data", int'(arr_wdata), int'(e.d));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        spi_mosi = b;
        wait_clk(HALF);
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) spi_bit(v[i]);
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_wren();
        cs_low();
        spi_byte(8'h06);
        cs_high();
    endtask

    task automatic send_pp(input logic [23:0] addr, input int n, input int extra_bits);
        cs_low();
        spi_byte(8'h02);
        spi_byte(addr[23:16]);
        spi_byte(addr[15:8]);
        spi_byte(addr[7:0]);
        for (int k = 0; k < n; k++) spi_byte(payload[k]);
        for (int b = 0; b < extra_bits; b++) spi_bit(1'b1);
        cs_high();
    endtask

    // expected writes: last byte per offset wins, ascending offsets, old AND new
    task automatic push_expected(input logic [23:0] addr, input int n);
        logic [7:0] nb [0:255];
        bit         got [0:255];
        logic [AW_K-1:0] base;
        for (int o = 0; o < 256; o++) begin
            got[o] = 1'b0;
            nb[o]  = 8'h00;
        end
        for (int k = 0; k < n; k++) begin
            int o;
            o = (int'(addr[7:0]) + k) % 256;
            nb[o]  = payload[k];
            got[o] = 1'b1;
        end
        base = {addr[21:8], 8'h00};
        for (int o = 0; o < 256; o++) begin
            if (got[o]) begin
                exp_t e;
                e.a = base + AW_K'(o);
                e.d = mem[{base[9:8], 8'(o)}] & nb[o];
                sb_q.push_back(e);
            end
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (wip && guard < 5 * T_PP) begin
            wait_clk(1);
            guard++;
        end
        wait_clk(2);
    endtask

    task automatic run_pp_ok(input logic [23:0] addr, input int n, input string req);
        push_expected(addr, n);
        wip_cycles = 0;
        send_pp(addr, n, 0);
        check(wip == 1'b1, req, "wip after accepted command", int'(wip), 1);
        wait_idle();
        check(wip_cycles == T_PP, "R7", "wip length", wip_cycles, T_PP);
        check(wel == 1'b0, "R8", "wel after cycle", int'(wel), 0);
        check(sb_q.size() == 0, "R5", "writes still pending", sb_q.size(), 0);
    endtask

    task automatic run_pp_dropped(input logic [23:0] addr, input int n, input int extra,
                                  input logic exp_wel, input string req);
        send_pp(addr, n, extra);
        wait_clk(40);
        check(wip == 1'b0, req, "wip after dropped command", int'(wip), 0);
        check(wel == exp_wel, req, "wel after dropped command", int'(wel), int'(exp_wel));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        for (int i = 0; i < 300; i++) payload[i] = 8'(i * 7 + 3);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        check(wip == 1'b0, "R7", "wip after reset", int'(wip), 0);
        check(wel == 1'b0, "R1", "wel after reset", int'(wel), 0);

        // R2: program without write enable is ignored
        run_pp_dropped(24'h000040, 3, 0, 1'b0, "R2");

        // R1: write enable sets the flag
        send_wren();
        check(wel == 1'b1, "R1", "wel after write enable", int'(wel), 1);

        // R3 R5 R7 R8: basic program, four bytes at offset 10h
        run_pp_ok(24'h000010, 4, "R3");

        // R6: select rises mid-byte
        send_wren();
        run_pp_dropped(24'h000020, 2, 3, 1'b1, "R6");
        // R6: no data byte at all
        run_pp_dropped(24'h000020, 0, 0, 1'b1, "R6");

        // R9: locked page
        lock_pg = 14'd1;
        lock_en = 1'b1;
        run_pp_dropped(24'h000130, 2, 0, 1'b1, "R9");
        lock_en = 1'b0;

        // R3 R10: wrap at page end, top address bits ignored
        run_pp_ok(24'hC001FE, 5, "R10");
        check(mem[10'h100] == payload[2], "R3", "wrapped byte at offset 0",
              int'(mem[10'h100]), int'(payload[2]));

        // R4: 260 bytes from offset 05h, last 256 kept
        send_wren();
        run_pp_ok(24'h000205, 260, "R4");
        check(mem[10'h205] == payload[256], "R4", "offset 05h holds byte 256",
              int'(mem[10'h205]), int'(payload[256]));
        check(mem[10'h209] == payload[4], "R4", "offset 09h holds byte 4",
              int'(mem[10'h209]), int'(payload[4]));

        // R11: program twice, bits only clear
        payload[0] = 8'hF3;
        send_wren();
        run_pp_ok(24'h000080, 1, "R11");
        payload[0] = 8'h3F;
        send_wren();
        run_pp_ok(24'h000080, 1, "R11");
        check(mem[10'h080] == 8'h33, "R11", "AND of two programs",
              int'(mem[10'h080]), 8'h33);
        check(mem[10'h081] == 8'hFF, "R5", "neighbour untouched",
              int'(mem[10'h081]), 8'hFF);

        // R12: commands during the cycle are ignored
        payload[0] = 8'h5A;
        send_wren();
        push_expected(24'h000300, 1);
        send_pp(24'h000300, 1, 0);
        send_wren();
        payload[0] = 8'h00;
        send_pp(24'h000310, 1, 0);
        check(cmd_page == 14'd3, "R12", "page held during cycle", int'(cmd_page), 3);
        wait_idle();
        check(wel == 1'b0, "R12", "write enable during cycle ignored", int'(wel), 0);
        check(sb_q.size() == 0, "R12", "writes still pending", sb_q.size(), 0);
        check(mem[10'h310] == 8'hFF, "R12", "program during cycle ignored",
              int'(mem[10'h310]), 8'hFF);
        check(mem[10'h300] == 8'h5A, "R3", "first program landed",
              int'(mem[10'h300]), 8'h5A);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule